// File: doc/BRIEF.md
# Serial 010 Detector with 100 Lockout

This block watches a serial stream of single bits and raises its match flag when the three most recently accepted bits read 0, then 1, then 0. Matches may overlap, so in 0,1,0,1,0 the last 0 of one match is also the first 0 of the next. The stream can also contain the forbidden run 1,0,0. Once that run has been accepted anywhere since the last reset, the block is locked out. In that condition the match flag stays low whatever bits follow, until the next reset.

Bits enter through a valid/ready handshake. One bit is consumed on each rising clock edge where `in_valid` and `in_ready` are both high. The block never applies back-pressure. `in_ready` drops only as a result of reset and comes back high one edge after reset is released. A sender that keeps `in_valid` low simply pauses the stream.

The match flag is a Moore output. It is decoded from the registered state alone, so it changes only on a clock edge and cannot glitch when the input changes. The lockout condition is one of the encoded states, not a separate flag. A parameter selects a binary or a one-hot state register.

Top module: `serial_pattern_guard`

## Requirements
- R1: Reset is synchronous and active high. In the cycle after any edge with `rst` high, `match_o` is 0. After reset the block behaves as if no bits had been seen, and any earlier lockout is cleared.
- R2: `match_o` is 1 in the cycle after the edge that accepts a 0 bit, provided the two bits accepted just before it were 0 and then 1 and the block is not locked out.
- R3: Overlapping matches each produce a flag. The accepted stream 0,0,1,0,1,0,1,0,0,1,0 gives `match_o` values 0,0,0,1,0,1,0,1,0,0,0, one per accepted bit.
- R4: Once the accepted bits 1,0,0 occur in sequence, `match_o` stays 0 for every later bit until reset. For 1,1,0,1,1,0,1,0,0,1,0 the values are 0,0,0,0,0,0,0,1,0,0,0.
- R5: A bit is accepted only on an edge where `in_valid` and `in_ready` are both high. On any other edge the state, and with it `match_o`, is unchanged.
- R6: `in_ready` is 0 in the cycle after an edge with `rst` high, and 1 in the cycle after an edge with `rst` low.
- R7: `match_o` stays high for no more than one accepted bit. The next accepted bit clears it, whatever its value.
- R8: A run of 0s with no 1 before it never causes lockout, and a run of 1s never raises the flag. After 0,0,0,0,0 then 1,0 the flag is raised. After 1,1,1,1 then 0,0 the block is locked out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A serial bit is offered on `in_bit` |
| in_ready | output | 1 | The block will take the offered bit on this edge |
| in_bit | input | 1 | Serial data bit |
| match_o | output | 1 | Last three accepted bits are 0,1,0 and no lockout has occurred |

## Verification
Two events can meet at the same clock edge. The first is a reset that arrives while a bit is being offered: reset must win, and the bit must be dropped rather than counted. The second is a bit that completes 1,0,0 arriving on the edge right after a match: the flag must fall and then stay low. The bench raises `rst` with `in_valid` held high. It also sends back-to-back streams such as 0,1,0,0. A reference history model with a sticky lockout flag judges every accepted bit, and during idle cycles the bench checks that the flag holds its value.

// File: rtl/rec_pkg.sv
package rec_pkg;

  localparam int STATE_W    = 3;
  localparam int NUM_STATES = 7;

  // Progress through the two patterns; ST_LOCK absorbs forever.
  typedef enum logic [STATE_W-1:0] {
    ST_EMPTY = 3'd0,  // nothing useful seen
    ST_Z     = 3'd1,  // ends in 0, not preceded by 1
    ST_ZO    = 3'd2,  // ends in 0,1
    ST_ZOZ   = 3'd3,  // ends in 0,1,0  (flag)
    ST_O     = 3'd4,  // ends in 1, not preceded by 0
    ST_OZ    = 3'd5,  // ends in 1,0
    ST_LOCK  = 3'd6   // 1,0,0 has been seen
  } rec_state_e;

endpackage

// File: rtl/rec_next_state.sv
module rec_next_state
  import rec_pkg::*;
(
  input  rec_state_e cur,
  input  logic       accept,
  input  logic       bit_in,
  output rec_state_e nxt
);

  rec_state_e step;

  always_comb begin
    step = cur;
    unique case (cur)
      ST_EMPTY: step = bit_in ? ST_O  : ST_Z;
      ST_Z:     step = bit_in ? ST_ZO : ST_Z;
      ST_ZO:    step = bit_in ? ST_O  : ST_ZOZ;
      ST_ZOZ:   step = bit_in ? ST_ZO : ST_LOCK;
      ST_O:     step = bit_in ? ST_O  : ST_OZ;
      ST_OZ:    step = bit_in ? ST_ZO : ST_LOCK;
      ST_LOCK:  step = ST_LOCK;
      default:  step = ST_EMPTY;
    endcase
  end

  assign nxt = accept ? step : cur;

endmodule

// File: rtl/rec_state_reg.sv
module rec_state_reg
  import rec_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
)(
  input  logic       clk,
  input  logic       rst,
  input  rec_state_e nxt,
  output rec_state_e cur
);

  generate
    if (ONE_HOT) begin : g_onehot
      logic [NUM_STATES-1:0] hot_q;
      logic [NUM_STATES-1:0] hot_d;

      always_comb begin
        hot_d      = '0;
        hot_d[nxt] = 1'b1;
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          hot_q           <= '0;
          hot_q[ST_EMPTY] <= 1'b1;
        end else begin
          hot_q <= hot_d;
        end
      end

      always_comb begin
        cur = ST_EMPTY;
        for (int i = 0; i < NUM_STATES; i++) begin
          if (hot_q[i]) cur = rec_state_e'(STATE_W'(i));
        end
      end
    end else begin : g_binary
      rec_state_e st_q;

      always_ff @(posedge clk) begin
        if (rst) st_q <= ST_EMPTY;
        else     st_q <= nxt;
      end

      assign cur = st_q;
    end
  endgenerate

endmodule

// File: rtl/rec_out_decode.sv
module rec_out_decode
  import rec_pkg::*;
(
  input  rec_state_e cur,
  output logic       match
);

  // Moore output: a function of the registered state only.
  assign match = (cur == ST_ZOZ);

endmodule

// File: rtl/serial_pattern_guard.sv
module serial_pattern_guard
  import rec_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
)(
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic match_o
);

  rec_state_e cur_state;
  rec_state_e nxt_state;
  logic       ready_q;
  logic       accept;

  always_ff @(posedge clk) begin
    ready_q <= ~rst;
  end

  assign in_ready = ready_q;
  assign accept   = in_valid & ready_q;

  rec_next_state u_next (
    .cur    (cur_state),
    .accept (accept),
    .bit_in (in_bit),
    .nxt    (nxt_state)
  );

  rec_state_reg #(.ONE_HOT(ONE_HOT)) u_reg (
    .clk (clk),
    .rst (rst),
    .nxt (nxt_state),
    .cur (cur_state)
  );

  rec_out_decode u_dec (
    .cur   (cur_state),
    .match (match_o)
  );

endmodule

// File: rtl/rec_guard_checker.sv
module rec_guard_checker
  import rec_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_bit,
  input logic       match_o,
  input rec_state_e cur_state
);

  a_r2_rise_after_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(match_o) |-> $past(in_valid && in_ready && !in_bit));

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(match_o));

  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    (cur_state == ST_LOCK) |=> (cur_state == ST_LOCK));

  a_r4_quiet_locked: assert property (@(posedge clk) disable iff (rst)
    (cur_state == ST_LOCK) |-> !match_o);

  a_r6_ready_low_after_reset: assert property (@(posedge clk)
    rst |=> !in_ready);

  a_r7_match_one_beat: assert property (@(posedge clk) disable iff (rst)
    (match_o && in_valid && in_ready) |=> !match_o);

endmodule

bind serial_pattern_guard rec_guard_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_bit    (in_bit),
  .match_o   (match_o),
  .cur_state (cur_state)
);

// File: tb/serial_pattern_guard_tb.sv
module serial_pattern_guard_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic in_ready;
  logic match_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  serial_pattern_guard u_dut (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_bit   (in_bit),
    .match_o  (match_o)
  );

  // reference model: bit history plus sticky lockout
  logic [1:0] hist;
  int         seen;
  bit         locked;
  bit         exp_q[$];
  string      tag = "R1";

  task automatic model_clear();
    hist = 2'b00; seen = 0; locked = 1'b0;
  endtask

  function automatic bit model_step(input bit b);
    logic [2:0] last3;
    last3 = {hist, b};
    if (seen >= 2 && last3 == 3'b100) locked = 1'b1;
    hist = {hist[0], b};
    model_step = !locked && seen >= 2 && last3 == 3'b010;
    seen++;
  endfunction

  task automatic check(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // driver: called at a negedge, returns at a negedge
  task automatic send(input bit b, input int gap);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_bit   = b;
    exp_q.push_back(model_step(b));
    @(negedge clk);
    in_valid = 1'b0;
    in_bit   = 1'($urandom);
    repeat (gap) @(negedge clk);
  endtask

  task automatic send_seq(input string req, input bit bits[], input int gap);
    tag = req;
    foreach (bits[i]) send(bits[i], gap);
  endtask

  task automatic do_reset(input bit offer);
    rst      = 1'b1;
    in_valid = offer;
    in_bit   = 1'b0;
    model_clear();
    repeat (2) @(negedge clk);
    rst      = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  // monitor
  bit acc_seen = 1'b0;
  bit rst_seen = 1'b1;
  bit last_exp = 1'b0;

  always @(posedge clk) begin
    acc_seen <= in_valid && in_ready && !rst;
    rst_seen <= rst;
  end

  always @(negedge clk) begin
    if (!done) begin
      if (rst_seen) begin
        check("R1", match_o, 1'b0);
        check("R6", in_ready, 1'b0);
        last_exp = 1'b0;
      end else if (acc_seen) begin
        if (exp_q.size() == 0) begin
          check("R5", 1'b1, 1'b0);
        end else begin
          last_exp = exp_q.pop_front();
          check(tag, match_o, last_exp);
        end
        check("R6", in_ready, 1'b1);
      end else begin
        check("R5", match_o, last_exp);
      end
    end
  end

  task automatic summary();
    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    model_clear();
    @(negedge clk);
    do_reset(1'b0);

    send_seq("R2", '{1'b0, 1'b1, 1'b0}, 3);           // flag held through idle
    send_seq("R3", '{1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0}, 0);
    do_reset(1'b1);                                    // reset while a bit is offered
    send_seq("R1", '{1'b0, 1'b1, 1'b0}, 0);
    do_reset(1'b0);
    send_seq("R4", '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0}, 1);
    do_reset(1'b0);
    send_seq("R8", '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0}, 0);
    do_reset(1'b0);
    send_seq("R8", '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0}, 0);
    do_reset(1'b0);
    send_seq("R7", '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0}, 0);

    tag = "R7";
    for (int n = 0; n < 1500; n++) begin
      if ($urandom_range(39) == 0) begin
        do_reset($urandom_range(1) == 1);
        tag = "R7";
      end
      send(1'($urandom), ($urandom_range(3) == 0) ? int'($urandom_range(2)) : 0);
    end

    repeat (2) @(negedge clk);
    check("R5", exp_q.size() == 0, 1'b1);
    summary();
  end

endmodule